// File: doc/BRIEF.md
# String Store Byte Sequencer

This block carries out a bulk store of bytes drawn from consecutive general-purpose registers. It takes one decoded 32-bit instruction word and reads the base address and the source data through a single combinational read port on a 32-entry, 32-bit register file. It then issues one byte write per accepted cycle on a valid/ready memory write channel. The count of bytes to store sits in the instruction itself, and a count of zero stands for the largest case, 32 bytes.

When reservation tracking is on and some agent holds a reservation, the block first sends invalidate requests for the reservation lines covered by the store. It sends one for the line of the first byte and, only if it is a different line, one for the line of the last byte. Both complete before any byte write is offered. A one-cycle done pulse marks the end of the store. An instruction word with the wrong opcode produces a one-cycle illegal pulse and no traffic on either request channel.

Top module: `strstore_seq`

## Requirements
- R1: An instruction is legal only when `ins_word[31:26]` equals 31 and `ins_word[10:1]` equals 725; bit 0 is ignored. An accepted illegal word raises `illegal` for exactly the next cycle, with no invalidate and no byte write, and the block stays idle.
- R2: The first source register index is `ins_word[25:21]`, the base register index is `ins_word[20:16]` and the byte count field is `ins_word[15:11]`.
- R3: A byte count field of 0 stores 32 bytes; a value of 1 to 31 stores that many bytes.
- R4: A base register index of 0 gives a base address of zero and does not read register 0. The base register is never written.
- R5: Each source register gives up its bytes most-significant first (bits 31:24, 23:16, 15:8, 7:0). Successive bytes go to successive addresses starting at the base address.
- R6: After four bytes the source index steps by one modulo 32, so register 31 is followed by register 0.
- R7: When the count is not a multiple of four, only the leading bytes of the last register are written.
- R8: The write address steps by one per byte and wraps from 0xFFFFFFFF to 0x00000000. Any alignment is accepted.
- R9: If `resv_enable` and `resv_active` are both high, an invalidate is issued for the line of the first byte and then, only if the line differs, for the line of byte (base + count − 1). A line address is the byte address with its low log2(LINE_BYTES) bits cleared. No invalidate is issued otherwise.
- R10: Every invalidate is accepted before the first byte write is offered. A write or invalidate request that is not yet accepted holds its address and data stable.
- R11: `ins_ready` is high only when the block is idle, which includes the cycle after reset. `done` is high for exactly the one cycle after the final byte write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_word | input | 32 | Instruction word |
| ins_ready | output | 1 | Block idle and accepting an instruction |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| resv_enable | input | 1 | Reservation tracking switched on |
| resv_active | input | 1 | At least one reservation currently held |
| inv_valid | output | 1 | Invalidate request valid |
| inv_line_addr | output | 32 | Line address to invalidate |
| inv_ready | input | 1 | Invalidate request accepted |
| wr_valid | output | 1 | Byte write valid |
| wr_addr | output | 32 | Byte write address |
| wr_data | output | 8 | Byte write data |
| wr_ready | input | 1 | Byte write accepted |
| done | output | 1 | One-cycle pulse after the last byte is accepted |
| illegal | output | 1 | One-cycle pulse after an illegal word is accepted |

## Verification
A 32-byte store that starts at register 28 exercises the zero-count encoding and the wrap of the register index. A design that stops at 31 bytes, or that moves to register 32 instead of register 0, writes the wrong bytes in the second half. A store whose base address sits two bytes below the top of the address space checks both address wrap and the two-line invalidate case. A wrong line mask, a missing second invalidate or a write that overtakes an invalidate appears as a mismatch in the invalidate sequence or as a write seen too early. Counts of 5 and 7 check truncation of the last register, a base index of zero checks that register 0 is not used as the base, and stall patterns on both ready inputs check that a held request neither drops nor changes.

// File: rtl/strstore_pkg.sv
package strstore_pkg;

    localparam int unsigned PRIMARY_OP = 31;
    localparam int unsigned EXTENDED_OP = 725;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BASE,
        S_INV_FIRST,
        S_INV_LAST,
        S_STORE
    } seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        logic [4:0]  src_idx;
        logic [4:0]  base_idx;
        logic [5:0]  left;
        logic [1:0]  byte_idx;
        logic [31:0] ea;
        logic        done;
        logic        illegal;
    } seq_regs_t;

endpackage

// File: rtl/strstore_decode.sv
module strstore_decode (
    input  logic [31:0] word,
    output logic        legal,
    output logic [4:0]  src_idx,
    output logic [4:0]  base_idx,
    output logic [5:0]  byte_cnt
);
    import strstore_pkg::*;

    logic [4:0] cnt_field;

    always_comb begin
        legal     = (word[31:26] == 6'(PRIMARY_OP)) && (word[10:1] == 10'(EXTENDED_OP));
        src_idx   = word[25:21];
        base_idx  = word[20:16];
        cnt_field = word[15:11];
        byte_cnt  = (cnt_field == 5'd0) ? 6'd32 : {1'b0, cnt_field};
    end
endmodule

// File: rtl/strstore_byte_pick.sv
module strstore_byte_pick #(
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [WORD_BYTES*8-1:0]       word,
    input  logic [$clog2(WORD_BYTES)-1:0] idx,
    output logic [7:0]                    byte_out
);
    localparam int unsigned LANES = WORD_BYTES;

    logic [7:0] lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // lane 0 is the most significant byte
        assign lane[g] = word[(LANES-1-g)*8 +: 8];
    end

    assign byte_out = lane[idx];
endmodule

// File: rtl/strstore_seq.sv
module strstore_seq #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LINE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [31:0]       ins_word,
    output logic              ins_ready,
    output logic [4:0]        rf_raddr,
    input  logic [31:0]       rf_rdata,
    input  logic              resv_enable,
    input  logic              resv_active,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_line_addr,
    input  logic              inv_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ready,
    output logic              done,
    output logic              illegal
);
    import strstore_pkg::*;

    localparam logic [ADDR_W-1:0] LINE_MASK = ~(ADDR_W'(LINE_BYTES - 1));

    seq_regs_t q, d;

    logic        dec_legal;
    logic [4:0]  dec_src;
    logic [4:0]  dec_base;
    logic [5:0]  dec_cnt;
    logic [7:0]  picked;
    logic [ADDR_W-1:0] first_line, last_line;

    strstore_decode u_decode (
        .word     (ins_word),
        .legal    (dec_legal),
        .src_idx  (dec_src),
        .base_idx (dec_base),
        .byte_cnt (dec_cnt)
    );

    strstore_byte_pick #(.WORD_BYTES(4)) u_pick (
        .word     (rf_rdata),
        .idx      (q.byte_idx),
        .byte_out (picked)
    );

    always_comb begin
        first_line = q.ea & LINE_MASK;
        last_line  = (q.ea + ADDR_W'(q.left) - ADDR_W'(1)) & LINE_MASK;
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.illegal = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (ins_valid) begin
                    if (dec_legal) begin
                        d.src_idx  = dec_src;
                        d.base_idx = dec_base;
                        d.left     = dec_cnt;
                        d.byte_idx = 2'd0;
                        d.st       = S_BASE;
                    end else begin
                        d.illegal = 1'b1;
                    end
                end
            end
            S_BASE: begin
                d.ea = (q.base_idx == 5'd0) ? '0 : ADDR_W'(rf_rdata);
                d.st = (resv_enable && resv_active) ? S_INV_FIRST : S_STORE;
            end
            S_INV_FIRST: begin
                if (inv_ready) begin
                    d.st = (last_line != first_line) ? S_INV_LAST : S_STORE;
                end
            end
            S_INV_LAST: begin
                if (inv_ready) begin
                    d.st = S_STORE;
                end
            end
            S_STORE: begin
                if (wr_ready) begin
                    d.ea       = q.ea + ADDR_W'(1);
                    d.left     = q.left - 6'd1;
                    d.byte_idx = q.byte_idx + 2'd1;
                    if (q.byte_idx == 2'd3) begin
                        d.src_idx = q.src_idx + 5'd1;
                    end
                    if (q.left == 6'd1) begin
                        d.st   = S_IDLE;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= S_IDLE;
            q.src_idx  <= '0;
            q.base_idx <= '0;
            q.left     <= '0;
            q.byte_idx <= '0;
            q.ea       <= '0;
            q.done     <= 1'b0;
            q.illegal  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ins_ready     = (q.st == S_IDLE);
    assign rf_raddr      = (q.st == S_BASE) ? q.base_idx : q.src_idx;
    assign inv_valid     = (q.st == S_INV_FIRST) || (q.st == S_INV_LAST);
    assign inv_line_addr = (q.st == S_INV_LAST) ? last_line : first_line;
    assign wr_valid      = (q.st == S_STORE);
    assign wr_addr       = q.ea;
    assign wr_data       = picked;
    assign done          = q.done;
    assign illegal       = q.illegal;

    // R1: an illegal pulse comes with no request traffic
    assert_illegal_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_valid && !inv_valid && ins_ready));

    // R10: a stalled byte write keeps its address and data
    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R10: a stalled invalidate keeps its line address
    assert_inv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_line_addr)));

    // R10: invalidate and byte write never overlap
    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inv_valid, wr_valid}));

    // R9: invalidate addresses are line aligned
    assert_line_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_line_addr & ~LINE_MASK) == '0));

    // R11: done follows an accepted byte write
    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_valid && wr_ready));

    // R11: not ready while requests are pending
    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || inv_valid) |-> !ins_ready);

    // R1 R11: the two pulses never coincide
    assert_pulse_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));
endmodule

// File: tb/strstore_seq_tb_top.sv
module strstore_seq_tb_top;
    localparam int unsigned LINE_BYTES = 128;
    localparam logic [31:0] LMASK = ~(32'(LINE_BYTES - 1));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [31:0] ins_word = '0;
    logic        ins_ready;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        resv_enable = 1'b0;
    logic        resv_active = 1'b0;
    logic        inv_valid;
    logic [31:0] inv_line_addr;
    logic        inv_ready = 1'b0;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ready = 1'b0;
    logic        done;
    logic        illegal;

    logic [31:0] gpr [32];
    int checks = 0;
    int failures = 0;

    logic [31:0] exp_inv [$];
    logic [31:0] exp_addr [$];
    logic [7:0]  exp_data [$];

    always #2.5 clk = ~clk;

    assign rf_rdata = gpr[rf_raddr];

    strstore_seq #(.ADDR_W(32), .LINE_BYTES(LINE_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
        .ins_ready(ins_ready), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .resv_enable(resv_enable), .resv_active(resv_active),
        .inv_valid(inv_valid), .inv_line_addr(inv_line_addr), .inv_ready(inv_ready),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] ra, input logic [4:0] nb,
                                       input logic [9:0] xo);
        return {op, rs, ra, nb, xo, 1'b0};
    endfunction

    // behavioural expectation built from the requirements
    task automatic build(input int rs, input int ra, input int nb, input bit en, input bit act);
        logic [31:0] ea, lastb;
        int n;
        exp_inv.delete(); exp_addr.delete(); exp_data.delete();
        ea = (ra == 0) ? 32'h0 : gpr[ra];
        n  = (nb == 0) ? 32 : nb;
        lastb = ea + 32'(n) - 32'd1;
        if (en && act) begin
            exp_inv.push_back(ea & LMASK);
            if ((lastb & LMASK) != (ea & LMASK)) exp_inv.push_back(lastb & LMASK);
        end
        for (int i = 0; i < n; i++) begin
            int r;
            logic [31:0] w;
            r = (rs + i / 4) % 32;
            w = gpr[r];
            exp_addr.push_back(ea + 32'(i));
            exp_data.push_back(8'(w >> (24 - 8 * (i % 4))));
        end
    endtask

    task automatic run(input string req, input logic [31:0] word, input bit legal, input int stall);
        bit seen_end = 1'b0;
        bit want_done = 1'b0;
        @(negedge clk);
        ins_valid = 1'b1;
        ins_word  = word;
        @(negedge clk);
        ins_valid = 1'b0;
        ins_word  = $urandom;
        for (int cyc = 0; cyc < 400 && !seen_end; cyc++) begin
            if (cyc > 0) @(negedge clk);
            wr_ready  = (stall == 0) ? 1'b1 : ((cyc % (stall + 1)) == 0);
            inv_ready = (stall == 0) ? 1'b1 : ((cyc % 2) == 1);
            #1;
            if (!legal) begin
                check(illegal == 1'b1, req, "illegal pulse", 32'(illegal), 32'd1);
                check(!wr_valid && !inv_valid, req, "no traffic on illegal",
                      32'({wr_valid, inv_valid}), 32'd0);
                @(negedge clk); #1;
                check(!illegal && ins_ready && !wr_valid && !inv_valid, req,
                      "idle after illegal", 32'({illegal, ins_ready, wr_valid, inv_valid}), 32'b0100);
                seen_end = 1'b1;
            end else if (want_done) begin
                check(done == 1'b1, "R11", "done pulse after last byte", 32'(done), 32'd1);
                check(ins_ready == 1'b1, "R11", "ready when idle", 32'(ins_ready), 32'd1);
                @(negedge clk); #1;
                check(done == 1'b0, "R11", "done lasts one cycle", 32'(done), 32'd0);
                seen_end = 1'b1;
            end else begin
                if (done || illegal || ins_ready) begin
                    check(1'b0, "R11", "busy flags", 32'({done, illegal, ins_ready}), 32'd0);
                end
                if (inv_valid && inv_ready) begin
                    if (exp_inv.size() == 0) begin
                        check(1'b0, req, "unexpected invalidate R9", inv_line_addr, 32'hx);
                    end else begin
                        check(inv_line_addr == exp_inv[0], req, "invalidate line R9",
                              inv_line_addr, exp_inv[0]);
                        void'(exp_inv.pop_front());
                    end
                end
                if (wr_valid && wr_ready) begin
                    if (exp_inv.size() != 0) begin
                        check(1'b0, "R10", "write before invalidates", wr_addr, exp_inv[0]);
                        exp_inv.delete();
                    end
                    if (exp_addr.size() == 0) begin
                        check(1'b0, req, "extra byte write", wr_addr, 32'hx);
                    end else begin
                        check(wr_addr == exp_addr[0], req, "write address", wr_addr, exp_addr[0]);
                        check(wr_data == exp_data[0], req, "write data", 32'(wr_data), 32'(exp_data[0]));
                        void'(exp_addr.pop_front());
                        void'(exp_data.pop_front());
                        if (exp_addr.size() == 0) want_done = 1'b1;
                    end
                end
            end
        end
        check(seen_end, req, "operation completed", 32'(seen_end), 32'd1);
        check(exp_addr.size() == 0 && exp_inv.size() == 0, req, "all expected traffic seen",
              32'(exp_addr.size() + exp_inv.size()), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) gpr[i] = {8'(i), 8'(i + 8'h40), 8'(i + 8'h80), 8'(i + 8'hC0)};
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        check(ins_ready && !wr_valid && !inv_valid && !done && !illegal, "R11", "reset state",
              32'({ins_ready, wr_valid, inv_valid, done, illegal}), 32'b10000);
        rst_n = 1'b1;

        // R5 R7 R2: 7 bytes from r3, base r5, partial last register
        gpr[5] = 32'h0000_1000;
        build(3, 5, 7, 0, 0);
        run("R5 R7 R2", mk(6'd31, 5'd3, 5'd5, 5'd7, 10'd725), 1'b1, 0);

        // R3 R6: count 0 means 32 bytes, r28 wraps to r0
        gpr[9] = 32'h0000_2000;
        build(28, 9, 0, 0, 0);
        run("R3 R6", mk(6'd31, 5'd28, 5'd9, 5'd0, 10'd725), 1'b1, 2);

        // R4: base index 0 gives zero, not the contents of r0
        gpr[0] = 32'hDEAD_BEEF;
        build(10, 0, 5, 0, 0);
        run("R4 R7", mk(6'd31, 5'd10, 5'd0, 5'd5, 10'd725), 1'b1, 1);

        // R8 R9: address wraps, two lines invalidated
        gpr[7] = 32'hFFFF_FFFE;
        resv_enable = 1'b1; resv_active = 1'b1;
        build(12, 7, 4, 1, 1);
        run("R8 R9 R10", mk(6'd31, 5'd12, 5'd7, 5'd4, 10'd725), 1'b1, 1);

        // R9: single line invalidate when both ends share a line
        gpr[8] = 32'h0000_2004;
        build(1, 8, 8, 1, 1);
        run("R9", mk(6'd31, 5'd1, 5'd8, 5'd8, 10'd725), 1'b1, 2);

        // R9: unaligned store crossing a line boundary
        gpr[8] = 32'h0000_307E;
        build(20, 8, 3, 1, 1);
        run("R9 R8", mk(6'd31, 5'd20, 5'd8, 5'd3, 10'd725), 1'b1, 0);

        // R9: tracking enabled but no holder, no invalidate
        resv_active = 1'b0;
        build(2, 8, 6, 1, 0);
        run("R9", mk(6'd31, 5'd2, 5'd8, 5'd6, 10'd725), 1'b1, 0);
        resv_enable = 1'b0;

        // R1: wrong extended opcode and wrong primary opcode
        build(0, 0, 1, 0, 0); exp_addr.delete(); exp_data.delete();
        run("R1", mk(6'd31, 5'd3, 5'd5, 5'd4, 10'd597), 1'b0, 0);
        run("R1", mk(6'd30, 5'd3, 5'd5, 5'd4, 10'd725), 1'b0, 0);

        // R1 R2: record bit set is still legal, single byte from r31
        build(31, 5, 1, 0, 0);
        run("R1 R2", mk(6'd31, 5'd31, 5'd5, 5'd1, 10'd725) | 32'd1, 1'b1, 3);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule